// File: doc/BRIEF.md
# Routable Level Interrupt Controller

This block collects 32 level-sensitive peripheral interrupt requests and steers each one onto one of eight CPU interrupt lines. Software enables sources through a mask register, observes the synchronized live request levels through a status register, and chooses each source's destination line through four routing registers. Each source has its own 4-bit routing field.

A CPU line is high while at least one source routed to it is both enabled and active. The handler reads mask and status, ANDs them, and services the lowest set bit. If its line was raised but that AND is zero, the handler treats the interrupt as spurious. Nothing is latched: a request stays pending exactly as long as its input stays high.

Register access is a single-cycle 32-bit write strobe plus a combinational read. Both use a byte offset.

Top module: `irq_route_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask reads 0x00000000, all four routing registers read 0x00000000, the status reads 0x00000000 and every CPU line is low.
- R2: Offset 0x00 holds the mask. A write stores all 32 bits, which read back unchanged. Bit n = 1 enables source n. A mask change affects the CPU lines from the clock edge that performs the write.
- R3: Offset 0x04 reads the status. Bit n equals source input n as sampled two clock edges earlier, through a two-flop synchronizer. Writes to 0x04 change nothing.
- R4: Offsets 0x08, 0x0C, 0x10 and 0x14 are routing registers. Each stores all 32 written bits and reads them back.
- R5: Routing registers map to sources in reverse address order: 0x14 serves sources 0–7, 0x10 serves 8–15, 0x0C serves 16–23 and 0x08 serves 24–31. Source n uses bits [(n mod 8)*4 +: 4] of its register.
- R6: CPU line k (k = 0..7) is high exactly when some source n has status bit n = 1, mask bit n = 1 and a routing field equal to k. The line is the OR over all such sources.
- R7: A routing field value from 8 to 15 connects its source to no CPU line.
- R8: Sources are level-sensitive. A line stays high for as long as its routed, enabled source is held high, and falls two edges after the source drops.
- R9: Any offset other than 0x00–0x14 (word-aligned) reads 0x00000000, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_irq | input | 32 | Level interrupt requests, bit n = source n |
| cpu_irq | output | 8 | CPU interrupt lines, bit k = line k |

## Verification
The assertions watch properties that must hold on every cycle. A raised CPU line must be backed by a pending source, an all-zero mask must keep every line quiet, a mask write must land on the next cycle, and the status must trail the inputs by exactly two edges. What a property cannot conveniently show is left to the bench scenarios: the reverse register-to-source mapping, fields 8–15 leading nowhere, the OR of two sources on one line, unmapped offsets, and the ignored status writes. The bench's behavioural model is compared against the CPU lines and the read port on every clock.

// File: rtl/irqr_pkg.sv
// Shared offsets and helpers for the routable interrupt controller.
// Assumes word-aligned byte offsets and 32-bit registers.
package irqr_pkg;
    localparam int OFF_MASK   = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_ROUTE0 = 'h08;
    localparam int WORD_BYTES = 4;

    // Routing register index (by address order) serving a source; reverse order
    function automatic int route_reg_of(input int src, input int per_reg, input int num_regs);
        return num_regs - 1 - (src / per_reg);
    endfunction
endpackage

// File: rtl/irqr_sync.sv
// Two-flop synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module irqr_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Two register stages, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/irqr_regs.sv
// Register file: mask and routing registers plus the read multiplexer.
// Assumes single-cycle write strobes; status is supplied from outside and
// is read-only. Unmapped offsets read zero and ignore writes.
module irqr_regs
    import irqr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int NUM_ROUTE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W-1:0]           status,
    output logic [DATA_W-1:0]           mask_q,
    output logic [NUM_ROUTE*DATA_W-1:0] route_flat,
    output logic [DATA_W-1:0]           rdata
);
    logic [DATA_W-1:0] route_q [NUM_ROUTE];

    // Mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en && addr == ADDR_W'(OFF_MASK))
            mask_q <= wdata;
    end

    for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
        localparam int ROFF = OFF_ROUTE0 + r * WORD_BYTES;

        // Routing register r write
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[r] <= '0;
            else if (wr_en && addr == ADDR_W'(ROFF))
                route_q[r] <= wdata;
        end

        assign route_flat[r*DATA_W +: DATA_W] = route_q[r];
    end

    // Read multiplexer keyed by byte offset
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_MASK))
            rdata = mask_q;
        else if (addr == ADDR_W'(OFF_STATUS))
            rdata = status;
        for (int r = 0; r < NUM_ROUTE; r++) begin
            if (addr == ADDR_W'(OFF_ROUTE0 + r * WORD_BYTES))
                rdata = route_q[r];
        end
    end
endmodule

// File: rtl/irqr_router.sv
// Steers pending sources onto CPU lines using per-source routing fields.
// Assumes routing registers are given in address order and serve source
// groups in reverse order; field values at or above NUM_CPU reach no line.
module irqr_router
    import irqr_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CPU   = 8,
    parameter int FIELD_W   = 4,
    parameter int DATA_W    = 32,
    parameter int NUM_ROUTE = 4
) (
    input  logic [NUM_SRC-1:0]          pending,
    input  logic [NUM_ROUTE*DATA_W-1:0] route_flat,
    output logic [NUM_CPU-1:0]          cpu_lines
);
    localparam int PER_REG = DATA_W / FIELD_W;

    logic [NUM_CPU-1:0] hit [NUM_SRC];

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam int REG_IDX = route_reg_of(n, PER_REG, NUM_ROUTE);
        localparam int LSB     = REG_IDX * DATA_W + (n % PER_REG) * FIELD_W;
        logic [FIELD_W-1:0] field;
        assign field = route_flat[LSB +: FIELD_W];
        for (genvar k = 0; k < NUM_CPU; k++) begin : g_dst
            assign hit[n][k] = pending[n] && (field == FIELD_W'(k));
        end
    end

    // OR-reduce every source's decoded destination onto the CPU lines
    always_comb begin
        cpu_lines = '0;
        for (int n = 0; n < NUM_SRC; n++)
            cpu_lines = cpu_lines | hit[n];
    end
endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the routable level interrupt controller. Synchronizes source
// levels, gates them with the mask and routes them to CPU lines.
// Assumes a single clock domain for the register port; sources may be
// asynchronous. Outputs are combinational from registered state.
module irq_route_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 8,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int PER_REG   = DATA_W / FIELD_W;
    localparam int NUM_ROUTE = NUM_SRC / PER_REG;

    logic [NUM_SRC-1:0]          status_q;
    logic [DATA_W-1:0]           mask_q;
    logic [NUM_ROUTE*DATA_W-1:0] route_flat;
    logic [NUM_SRC-1:0]          pending;

    irqr_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_irq),
        .sync_out (status_q)
    );

    irqr_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_ROUTE (NUM_ROUTE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status     (DATA_W'(status_q)),
        .mask_q     (mask_q),
        .route_flat (route_flat),
        .rdata      (reg_rdata)
    );

    // Pending = synchronized status gated by enable mask
    assign pending = status_q & mask_q[NUM_SRC-1:0];

    irqr_router #(
        .NUM_SRC   (NUM_SRC),
        .NUM_CPU   (NUM_CPU),
        .FIELD_W   (FIELD_W),
        .DATA_W    (DATA_W),
        .NUM_ROUTE (NUM_ROUTE)
    ) u_router (
        .pending    (pending),
        .route_flat (route_flat),
        .cpu_lines  (cpu_irq)
    );
endmodule

// File: rtl/irq_route_ctrl_chk.sv
// Checker for irq_route_ctrl, attached with bind. Observes ports plus the
// internal mask and synchronized status.
module irq_route_ctrl_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC-1:0] src_irq,
    input logic [NUM_SRC-1:0] status_q,
    input logic [DATA_W-1:0]  mask_q,
    input logic [NUM_CPU-1:0] cpu_irq
);
    logic [1:0] since_rst;

    // Count edges since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && cpu_irq == '0));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(0)) |=> (mask_q == $past(reg_wdata)));

    p_status_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (status_q == $past(src_irq, 2)));

    p_line_backed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> ((status_q & mask_q[NUM_SRC-1:0]) != '0));

    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (cpu_irq == '0));
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .src_irq   (src_irq),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .cpu_irq   (cpu_irq)
);

// File: tb/test_irq_route_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios with literal expected values.
module test_irq_route_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_irq = '0;
    logic [7:0]  cpu_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_s1, m_s2, m_mask;
    logic [31:0] m_rt [4];

    irq_route_ctrl i_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_irq(src_irq), .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_mask <= '0;
            for (int i = 0; i < 4; i++) m_rt[i] <= '0;
        end else begin
            m_s1 <= src_irq;
            m_s2 <= m_s1;
            if (reg_we) begin
                if (reg_addr == 5'h00) m_mask <= reg_wdata;
                else if (reg_addr == 5'h08) m_rt[0] <= reg_wdata;
                else if (reg_addr == 5'h0C) m_rt[1] <= reg_wdata;
                else if (reg_addr == 5'h10) m_rt[2] <= reg_wdata;
                else if (reg_addr == 5'h14) m_rt[3] <= reg_wdata;
            end
        end
    end

    function automatic logic [7:0] model_cpu();
        logic [7:0] v = '0;
        for (int n = 0; n < 32; n++) begin
            logic [31:0] word;
            int fld;
            if (n < 8) word = m_rt[3];
            else if (n < 16) word = m_rt[2];
            else if (n < 24) word = m_rt[1];
            else word = m_rt[0];
            fld = int'((word >> ((n % 8) * 4)) & 32'hF);
            if (m_s2[n] && m_mask[n] && fld < 8) v[fld] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] model_rd(input logic [4:0] a);
        case (a)
            5'h00: return m_mask;
            5'h04: return m_s2;
            5'h08: return m_rt[0];
            5'h0C: return m_rt[1];
            5'h10: return m_rt[2];
            5'h14: return m_rt[3];
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (cpu_irq !== model_cpu()) begin
                n_bad++;
                $display("FAIL R6 model cpu_irq actual=%h expected=%h", cpu_irq, model_cpu());
            end
            n_cmp++;
            if (reg_rdata !== model_rd(reg_addr)) begin
                n_bad++;
                $display("FAIL R4 model rdata@%h actual=%h expected=%h",
                         reg_addr, reg_rdata, model_rd(reg_addr));
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s read@%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic cpu_chk(input logic [7:0] exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (cpu_irq !== exp) begin
            n_bad++;
            $display("FAIL %s cpu_irq actual=%h expected=%h", tag, cpu_irq, exp);
        end
    endtask

    task automatic set_src(input logic [31:0] v);
        @(posedge clk); #1;
        src_irq = v;
        repeat (2) @(posedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h04, 32'h0, "R1");
        rd_chk(5'h08, 32'h0, "R1");
        rd_chk(5'h14, 32'h0, "R1");
        cpu_chk(8'h00, "R1");
        // R2: mask read/write
        wr(5'h00, 32'hA5A5_0F0F);
        rd_chk(5'h00, 32'hA5A5_0F0F, "R2");
        wr(5'h00, 32'hFFFF_FFFF);
        rd_chk(5'h00, 32'hFFFF_FFFF, "R2");
        // R4: routing read/write
        wr(5'h14, 32'h7654_3210);
        wr(5'h10, 32'h0123_4567);
        wr(5'h0C, 32'h3333_3333);
        wr(5'h08, 32'hFFFF_FFFF);
        rd_chk(5'h14, 32'h7654_3210, "R4");
        rd_chk(5'h10, 32'h0123_4567, "R4");
        rd_chk(5'h0C, 32'h3333_3333, "R4");
        rd_chk(5'h08, 32'hFFFF_FFFF, "R4");
        // R9: unmapped offset
        wr(5'h18, 32'hDEAD_BEEF);
        rd_chk(5'h18, 32'h0, "R9");
        wr(5'h1C, 32'h1234_5678);
        rd_chk(5'h1C, 32'h0, "R9");
        rd_chk(5'h00, 32'hFFFF_FFFF, "R9");
        rd_chk(5'h14, 32'h7654_3210, "R9");
        // R3: status write ignored
        wr(5'h04, 32'hFFFF_FFFF);
        rd_chk(5'h04, 32'h0, "R3");
        // R5: reverse register order
        set_src(32'h0000_0008);             // source 3 -> 0x14 field 3 = 3
        cpu_chk(8'h08, "R5");
        rd_chk(5'h04, 32'h0000_0008, "R3");
        set_src(32'h0000_0200);             // source 9 -> 0x10 field 1 = 6
        cpu_chk(8'h40, "R5");
        set_src(32'h0010_0000);             // source 20 -> 0x0C field 4 = 3
        cpu_chk(8'h08, "R5");
        // R7: field 0xF routes nowhere
        set_src(32'h4000_0000);             // source 30 -> 0x08 field 6 = F
        cpu_chk(8'h00, "R7");
        wr(5'h08, 32'h89AB_CDEF);
        set_src(32'hFF00_0000);
        cpu_chk(8'h00, "R7");
        // R6: two sources share line 3
        set_src(32'h0010_0008);
        cpu_chk(8'h08, "R6");
        set_src(32'h0010_0000);
        cpu_chk(8'h08, "R6");
        // R8: level hold and release; R2 mask effect
        set_src(32'h0000_0200);
        repeat (5) @(posedge clk);
        cpu_chk(8'h40, "R8");
        wr(5'h00, 32'hFFFF_FDFF);
        cpu_chk(8'h00, "R2");
        wr(5'h00, 32'hFFFF_FFFF);
        cpu_chk(8'h40, "R2");
        @(posedge clk); #1 src_irq = '0;
        @(posedge clk);
        cpu_chk(8'h40, "R8");
        @(posedge clk);
        cpu_chk(8'h00, "R8");
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            reg_we = ($urandom % 3) == 0;
            reg_addr = 5'(($urandom % 8) * 4);
            reg_wdata = $urandom;
            if (($urandom % 4) == 0) src_irq = $urandom & $urandom;
        end
        @(posedge clk); #1 reg_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule